// File: doc/BRIEF.md
# Legacy Disk Port Access Decoder

This block sits between a host I/O bus and the register file of a disk controller. It decodes each host access into one of two address windows. In the data window, byte accesses reach the task-file registers at the offset given. Word and doubleword accesses at the window base reach the data port. In the control window, one byte lane is live: a read of it returns alternate status and a write of it sets device control. Whether an access is legal depends on both its offset and its size. An illegal read returns all ones over the access width, and an illegal write is dropped.

The host presents an access for one cycle, with read or write, window select, offset, size in bytes and write data. In that same cycle the block pulses exactly one downstream strobe and drives the shared write-enable and write data. The downstream responders return read data combinationally in the strobe cycle. The block registers that data and presents it to the host one cycle later with a valid flag. All multi-byte values are little-endian: the byte at the lowest address sits in bits 7:0.

Top module: `dskport_decoder`

## Requirements
- R1: While reset is held, and after it is released with no access, `host_rvalid` is 0, `host_rdata` is 0 and no downstream strobe is high.
- R2: A control-window read with size 1 at offset 2 pulses `ctl_stb` with `dn_we`=0. One cycle later `host_rdata` holds `ctl_rdata` in bits 7:0 and zeros above.
- R3: A control-window write with size 1 at offset 2 pulses `ctl_stb` with `dn_we`=1 and `dn_wdata`=`host_wdata`.
- R4: Any other control-window access pulses no strobe. A read of it returns 0xFF for size 1, 0xFFFF for size 2 and 0xFFFFFFFF for size 4.
- R5: A data-window access with size 1 at any offset pulses `tf_stb` with `tf_off` equal to that offset. A read returns `tf_rdata` in bits 7:0 and zeros above.
- R6: A data-window access with size 2 at offset 0 pulses `d16_stb`. A read returns `d16_rdata` in bits 15:0 and zeros above, and a write passes `host_wdata` on `dn_wdata`.
- R7: A data-window access with size 4 at offset 0 pulses `d32_stb`. A read returns `d32_rdata` in all 32 bits, and a write passes `host_wdata` on `dn_wdata`.
- R8: A data-window access with size 2 or 4 at a nonzero offset pulses no strobe. A read of it returns all ones over the access width.
- R9: A size code other than 1, 2 or 4 pulses no strobe in either window. A read with such a code returns 0xFFFFFFFF.
- R10: At most one downstream strobe is high in any cycle. No strobe is high in a cycle without `host_rd` or `host_wr`.
- R11: `host_rvalid` is high in exactly the cycle after each read cycle, and back-to-back reads keep it high with fresh data each cycle.
- R12: A write, including a cycle with both `host_rd` and `host_wr` high, is treated as a write and produces no `host_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd | input | 1 | Host read request, one cycle per access |
| host_wr | input | 1 | Host write request, one cycle per access |
| host_win | input | 1 | Window select: 0 selects the data window, 1 selects the control window |
| host_off | input | 3 | Byte offset within the window |
| host_size | input | 3 | Access size in bytes; 1, 2 and 4 are legal |
| host_wdata | input | 32 | Write data, little-endian |
| host_rdata | output | 32 | Read data, valid when host_rvalid is high |
| host_rvalid | output | 1 | Read data valid, one cycle after the read |
| tf_stb | output | 1 | Task-file register byte access strobe |
| tf_off | output | 3 | Task-file register offset |
| tf_rdata | input | 8 | Task-file register read data |
| d16_stb | output | 1 | 16-bit data port strobe |
| d16_rdata | input | 16 | 16-bit data port read data |
| d32_stb | output | 1 | 32-bit data port strobe |
| d32_rdata | input | 32 | 32-bit data port read data |
| ctl_stb | output | 1 | Alternate status / device control strobe |
| ctl_rdata | input | 8 | Alternate status read data |
| dn_we | output | 1 | Downstream write enable, valid with a strobe |
| dn_wdata | output | 32 | Downstream write data, valid with a strobe |

## Verification
The strobes, `tf_off`, `dn_we` and `dn_wdata` are combinational from the host request, so they are due in the same cycle the request is presented. The bench drives each request on a falling edge and samples these outputs one nanosecond later. `host_rdata` and `host_rvalid` pass through one register and are due one cycle later. The bench samples them on the next falling edge, after the capturing rising edge, and removes the request at that point so that each vector is exactly one access. After reset is released, the two-stage reset synchronizer is given time to settle before the first vector. Back-to-back reads are checked on consecutive falling edges to confirm that the one-cycle offset holds without gaps.

// File: rtl/dskport_pkg.sv
package dskport_pkg;

  localparam int HOST_DW = 32;
  localparam int SZ_W    = 3;

  // Decoded class of one host access.
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_TF,
    ACC_D16,
    ACC_D32,
    ACC_CTL,
    ACC_BAD
  } acc_kind_e;

  localparam int NUM_STB = 4;

  // Strobe vector bit order: 0 task-file, 1 data16, 2 data32, 3 control.
  function automatic acc_kind_e stb_kind(input int idx);
    case (idx)
      0:       return ACC_TF;
      1:       return ACC_D16;
      2:       return ACC_D32;
      default: return ACC_CTL;
    endcase
  endfunction

  // All-ones fill for an illegal read, sized to the access width.
  function automatic logic [HOST_DW-1:0] fill_ones(input logic [SZ_W-1:0] sz);
    case (sz)
      3'd1:    return {{(HOST_DW-8){1'b0}}, 8'hFF};
      3'd2:    return {{(HOST_DW-16){1'b0}}, 16'hFFFF};
      default: return {HOST_DW{1'b1}};
    endcase
  endfunction

endpackage

// File: rtl/dskport_decode.sv
module dskport_decode
  import dskport_pkg::*;
#(
  parameter int OFF_W   = 3,
  parameter int CTL_OFF = 2
) (
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             win_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [SZ_W-1:0]  size_i,
  output acc_kind_e        kind_o,
  output logic             is_wr_o
);

  localparam logic [OFF_W-1:0] CTL_OFF_V = OFF_W'(CTL_OFF);

  logic at_base;
  assign at_base = (off_i == '0);

  always_comb begin
    kind_o = ACC_NONE;
    if (rd_i || wr_i) begin
      if (win_i) begin
        kind_o = (size_i == 3'd1 && off_i == CTL_OFF_V) ? ACC_CTL : ACC_BAD;
      end else begin
        case (size_i)
          3'd1:    kind_o = ACC_TF;
          3'd2:    kind_o = at_base ? ACC_D16 : ACC_BAD;
          3'd4:    kind_o = at_base ? ACC_D32 : ACC_BAD;
          default: kind_o = ACC_BAD;
        endcase
      end
    end
  end

  // A cycle carrying both requests is a write.
  assign is_wr_o = wr_i;

endmodule

// File: rtl/dskport_strobe.sv
module dskport_strobe
  import dskport_pkg::*;
#(
  parameter int OFF_W = 3
) (
  input  acc_kind_e           kind_i,
  input  logic                is_wr_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic [HOST_DW-1:0]  wdata_i,
  output logic [NUM_STB-1:0]  stb_o,
  output logic [OFF_W-1:0]    tf_off_o,
  output logic                we_o,
  output logic [HOST_DW-1:0]  wdata_o
);

  for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
    assign stb_o[g] = (kind_i == stb_kind(g));
  end

  logic fwd;
  assign fwd      = |stb_o;
  assign tf_off_o = stb_o[0] ? off_i : '0;
  assign we_o     = fwd && is_wr_i;
  // Hold the data lanes quiet unless a forwarded write is under way.
  assign wdata_o  = (fwd && is_wr_i) ? wdata_i : '0;

endmodule

// File: rtl/dskport_rdpath.sv
module dskport_rdpath
  import dskport_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  acc_kind_e          kind_i,
  input  logic               is_wr_i,
  input  logic [SZ_W-1:0]    size_i,
  input  logic [7:0]         tf_rdata_i,
  input  logic [15:0]        d16_rdata_i,
  input  logic [31:0]        d32_rdata_i,
  input  logic [7:0]         ctl_rdata_i,
  output logic [HOST_DW-1:0] rdata_o,
  output logic               rvalid_o
);

  logic               rd_fire;
  logic [HOST_DW-1:0] rdata_d;
  logic [HOST_DW-1:0] rdata_q;
  logic               rvalid_q;

  assign rd_fire = (kind_i != ACC_NONE) && !is_wr_i;

  always_comb begin
    case (kind_i)
      ACC_TF:  rdata_d = {{(HOST_DW-8){1'b0}}, tf_rdata_i};
      ACC_D16: rdata_d = {{(HOST_DW-16){1'b0}}, d16_rdata_i};
      ACC_D32: rdata_d = d32_rdata_i;
      ACC_CTL: rdata_d = {{(HOST_DW-8){1'b0}}, ctl_rdata_i};
      ACC_BAD: rdata_d = fill_ones(size_i);
      default: rdata_d = rdata_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_fire;
      if (rd_fire) begin
        rdata_q <= rdata_d;
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

endmodule

// File: rtl/dskport_decoder.sv
module dskport_decoder
  import dskport_pkg::*;
#(
  parameter int OFF_W   = 3,
  parameter int CTL_OFF = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic               host_win,
  input  logic [OFF_W-1:0]   host_off,
  input  logic [SZ_W-1:0]    host_size,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  output logic               host_rvalid,
  output logic               tf_stb,
  output logic [OFF_W-1:0]   tf_off,
  input  logic [7:0]         tf_rdata,
  output logic               d16_stb,
  input  logic [15:0]        d16_rdata,
  output logic               d32_stb,
  input  logic [31:0]        d32_rdata,
  output logic               ctl_stb,
  input  logic [7:0]         ctl_rdata,
  output logic               dn_we,
  output logic [HOST_DW-1:0] dn_wdata
);

  localparam logic [OFF_W-1:0] CTL_OFF_V = OFF_W'(CTL_OFF);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta;
  logic rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  acc_kind_e          kind;
  logic               is_wr;
  logic [NUM_STB-1:0] stb;

  dskport_decode #(
    .OFF_W   (OFF_W),
    .CTL_OFF (CTL_OFF)
  ) decode_i (
    .rd_i    (host_rd),
    .wr_i    (host_wr),
    .win_i   (host_win),
    .off_i   (host_off),
    .size_i  (host_size),
    .kind_o  (kind),
    .is_wr_o (is_wr)
  );

  dskport_strobe #(
    .OFF_W (OFF_W)
  ) strobe_i (
    .kind_i   (kind),
    .is_wr_i  (is_wr),
    .off_i    (host_off),
    .wdata_i  (host_wdata),
    .stb_o    (stb),
    .tf_off_o (tf_off),
    .we_o     (dn_we),
    .wdata_o  (dn_wdata)
  );

  dskport_rdpath rdpath_i (
    .clk         (clk),
    .rst_n       (rst_s),
    .kind_i      (kind),
    .is_wr_i     (is_wr),
    .size_i      (host_size),
    .tf_rdata_i  (tf_rdata),
    .d16_rdata_i (d16_rdata),
    .d32_rdata_i (d32_rdata),
    .ctl_rdata_i (ctl_rdata),
    .rdata_o     (host_rdata),
    .rvalid_o    (host_rvalid)
  );

  assign tf_stb  = stb[0];
  assign d16_stb = stb[1];
  assign d32_stb = stb[2];
  assign ctl_stb = stb[3];

  // Port-level checks against the requirements.
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({tf_stb, d16_stb, d32_stb, ctl_stb}));

  assert_strobe_needs_request_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (tf_stb || d16_stb || d32_stb || ctl_stb) |-> (host_rd || host_wr));

  assert_ctl_only_at_lane_R2: assert property (@(posedge clk) disable iff (!rst_s)
    ctl_stb |-> (host_win && host_size == 3'd1 && host_off == CTL_OFF_V));

  assert_ctl_write_fwd_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (ctl_stb && host_wr) |-> (dn_we && dn_wdata == host_wdata));

  assert_wide_at_base_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (d16_stb || d32_stb) |-> (!host_win && host_off == '0));

  assert_tf_offset_R5: assert property (@(posedge clk) disable iff (!rst_s)
    tf_stb |-> (tf_off == host_off && host_size == 3'd1));

  assert_rvalid_after_read_R11: assert property (@(posedge clk) disable iff (!rst_s)
    (host_rd && !host_wr) |=> host_rvalid);

  assert_write_no_rvalid_R12: assert property (@(posedge clk) disable iff (!rst_s)
    host_wr |=> !host_rvalid);

  assert_bad_ctl_read_ones_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (host_rd && !host_wr && host_win && !(host_size == 3'd1 && host_off == CTL_OFF_V))
      |=> (host_rdata == fill_ones($past(host_size))));

  assert_odd_size_silent_R9: assert property (@(posedge clk) disable iff (!rst_s)
    ((host_rd || host_wr) && host_size != 3'd1 && host_size != 3'd2 && host_size != 3'd4)
      |-> !(tf_stb || d16_stb || d32_stb || ctl_stb));

endmodule

// File: tb/dskport_decoder_tb_top.sv
`timescale 1ns/1ps
module dskport_decoder_tb_top;

  logic        clk;
  logic        rst_n;
  logic        host_rd, host_wr, host_win;
  logic [2:0]  host_off, host_size;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        tf_stb, d16_stb, d32_stb, ctl_stb;
  logic [2:0]  tf_off;
  logic [7:0]  tf_rdata, ctl_rdata;
  logic [15:0] d16_rdata;
  logic [31:0] d32_rdata;
  logic        dn_we;
  logic [31:0] dn_wdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Responders: fixed, recognisable read values.
  assign tf_rdata  = 8'hA0 | {5'b0, tf_off};
  assign d16_rdata = 16'hC3E1;
  assign d32_rdata = 32'h8765_4321;
  assign ctl_rdata = 8'h5A;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  dskport_decoder dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_rd(host_rd), .host_wr(host_wr), .host_win(host_win),
    .host_off(host_off), .host_size(host_size), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .tf_stb(tf_stb), .tf_off(tf_off), .tf_rdata(tf_rdata),
    .d16_stb(d16_stb), .d16_rdata(d16_rdata),
    .d32_stb(d32_stb), .d32_rdata(d32_rdata),
    .ctl_stb(ctl_stb), .ctl_rdata(ctl_rdata),
    .dn_we(dn_we), .dn_wdata(dn_wdata)
  );

  // Strobe encoding in vectors: bit0 tf, bit1 d16, bit2 d32, bit3 ctl.
  typedef struct packed {
    logic        win;
    logic [2:0]  off;
    logic [2:0]  size;
    logic        wr;
    logic [31:0] wdata;
    logic [3:0]  stb;
    logic [31:0] rdata;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 3'd1, 1'b0, 32'h0, 4'b0001, 32'h0000_00A0, 8'd5},  // R5
    '{1'b0, 3'd5, 3'd1, 1'b0, 32'h0, 4'b0001, 32'h0000_00A5, 8'd5},  // R5
    '{1'b0, 3'd7, 3'd1, 1'b0, 32'h0, 4'b0001, 32'h0000_00A7, 8'd5},  // R5
    '{1'b0, 3'd0, 3'd2, 1'b0, 32'h0, 4'b0010, 32'h0000_C3E1, 8'd6},  // R6
    '{1'b0, 3'd0, 3'd4, 1'b0, 32'h0, 4'b0100, 32'h8765_4321, 8'd7},  // R7
    '{1'b0, 3'd2, 3'd2, 1'b0, 32'h0, 4'b0000, 32'h0000_FFFF, 8'd8},  // R8
    '{1'b0, 3'd4, 3'd4, 1'b0, 32'h0, 4'b0000, 32'hFFFF_FFFF, 8'd8},  // R8
    '{1'b1, 3'd2, 3'd1, 1'b0, 32'h0, 4'b1000, 32'h0000_005A, 8'd2},  // R2
    '{1'b1, 3'd0, 3'd1, 1'b0, 32'h0, 4'b0000, 32'h0000_00FF, 8'd4},  // R4
    '{1'b1, 3'd2, 3'd2, 1'b0, 32'h0, 4'b0000, 32'h0000_FFFF, 8'd4},  // R4
    '{1'b1, 3'd2, 3'd4, 1'b0, 32'h0, 4'b0000, 32'hFFFF_FFFF, 8'd4},  // R4
    '{1'b0, 3'd0, 3'd3, 1'b0, 32'h0, 4'b0000, 32'hFFFF_FFFF, 8'd9},  // R9
    '{1'b0, 3'd0, 3'd0, 1'b0, 32'h0, 4'b0000, 32'hFFFF_FFFF, 8'd9},  // R9
    '{1'b1, 3'd2, 3'd7, 1'b0, 32'h0, 4'b0000, 32'hFFFF_FFFF, 8'd9},  // R9
    '{1'b0, 3'd3, 3'd1, 1'b1, 32'h0000_00E7, 4'b0001, 32'h0, 8'd5},  // R5 write
    '{1'b0, 3'd0, 3'd2, 1'b1, 32'h0000_B00C, 4'b0010, 32'h0, 8'd6},  // R6 write
    '{1'b0, 3'd0, 3'd4, 1'b1, 32'hDEAD_0123, 4'b0100, 32'h0, 8'd7},  // R7 write
    '{1'b1, 3'd2, 3'd1, 1'b1, 32'h0000_0004, 4'b1000, 32'h0, 8'd3},  // R3
    '{1'b1, 3'd3, 3'd1, 1'b1, 32'h0000_0011, 4'b0000, 32'h0, 8'd4},  // R4 dropped
    '{1'b0, 3'd2, 3'd4, 1'b1, 32'h1111_2222, 4'b0000, 32'h0, 8'd8},  // R8 dropped
    '{1'b0, 3'd0, 3'd6, 1'b1, 32'h3333_4444, 4'b0000, 32'h0, 8'd9}   // R9 dropped
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    host_rd = 0; host_wr = 0; host_win = 0;
    host_off = 0; host_size = 0; host_wdata = 0;
  endtask

  function automatic logic [3:0] stbs();
    return {ctl_stb, d32_stb, d16_stb, tf_stb};
  endfunction

  task automatic run_vec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    @(negedge clk);
    host_rd = !v.wr; host_wr = v.wr; host_win = v.win;
    host_off = v.off; host_size = v.size; host_wdata = v.wdata;
    #1;
    check(stbs() == v.stb, tag, "strobes", {28'b0, stbs()}, {28'b0, v.stb});
    if (v.stb[0])
      check(tf_off == v.off, tag, "tf_off", {29'b0, tf_off}, {29'b0, v.off});
    if (v.stb != 4'b0) begin
      check(dn_we == v.wr, tag, "dn_we", {31'b0, dn_we}, {31'b0, v.wr});
      if (v.wr)
        check(dn_wdata == v.wdata, tag, "dn_wdata", dn_wdata, v.wdata);
    end
    @(negedge clk);
    check(host_rvalid == !v.wr, tag, "rvalid", {31'b0, host_rvalid}, {31'b0, !v.wr});
    if (!v.wr)
      check(host_rdata == v.rdata, tag, "rdata", host_rdata, v.rdata);
    idle_inputs();
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check(host_rvalid == 0, "R1", "rvalid in reset", {31'b0, host_rvalid}, 32'h0);
    check(host_rdata == 0, "R1", "rdata in reset", host_rdata, 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: idle after release
    check(stbs() == 0, "R1", "strobes idle", {28'b0, stbs()}, 32'h0);
    check(host_rvalid == 0, "R1", "rvalid idle", {31'b0, host_rvalid}, 32'h0);
    check(host_rdata == 0, "R1", "rdata idle", host_rdata, 32'h0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10: idle cycle after traffic, no strobe and no valid
    @(negedge clk);
    check(stbs() == 0, "R10", "no request no strobe", {28'b0, stbs()}, 32'h0);
    check(host_rvalid == 0, "R11", "rvalid drops", {31'b0, host_rvalid}, 32'h0);

    // R12: read and write together act as a write
    @(negedge clk);
    host_rd = 1; host_wr = 1; host_win = 0; host_off = 3'd1; host_size = 3'd1;
    host_wdata = 32'h0000_0033;
    #1;
    check(tf_stb && dn_we, "R12", "rd+wr forwards write", {31'b0, dn_we}, 32'h1);
    check(dn_wdata == 32'h33, "R12", "rd+wr data", dn_wdata, 32'h33);
    @(negedge clk);
    check(host_rvalid == 0, "R12", "rd+wr no rvalid", {31'b0, host_rvalid}, 32'h0);
    idle_inputs();

    // R11: back-to-back reads
    @(negedge clk);
    host_rd = 1; host_win = 0; host_off = 3'd4; host_size = 3'd1;
    @(negedge clk);
    check(host_rvalid == 1, "R11", "b2b first valid", {31'b0, host_rvalid}, 32'h1);
    check(host_rdata == 32'hA4, "R11", "b2b first data", host_rdata, 32'hA4);
    host_off = 3'd0; host_size = 3'd4;
    @(negedge clk);
    check(host_rvalid == 1, "R11", "b2b second valid", {31'b0, host_rvalid}, 32'h1);
    check(host_rdata == 32'h8765_4321, "R11", "b2b second data", host_rdata, 32'h8765_4321);
    idle_inputs();
    @(negedge clk);
    check(host_rvalid == 0, "R11", "b2b end", {31'b0, host_rvalid}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule